// File: doc/BRIEF.md
# Hardware Breakpoint Slot Bank

This block holds a small bank of instruction-address comparators used as hardware breakpoints. A debug agent issues one of three commands on a 2-bit opcode with a 32-bit address: set, clear, or wipe all slots. On a set, the block first looks for an identical entry and, if none exists, places the entry in the lowest-numbered empty slot. On a clear, it finds the matching entry and empties that slot. A wipe empties every slot in one edge and is the command to use when execution halts.

An entry is stored as the requested address with bit 0 forced to one. That bit marks the slot as in use, so a stored value of zero means the slot is free. At the same time, the block compares a fetch address against every occupied slot and raises `hit` in the same cycle. The fetch comparison ignores bit 0 on both sides.

Every command completes in one edge. A one-cycle response follows in the next cycle. It carries the slot that was affected, a not-found flag and a bank-full flag.

A small state machine records which kind of command was last accepted and drives the response.

- `ST_IDLE`: no command was accepted on the last edge.
- `ST_SET_ACK`, `ST_CLR_ACK`, `ST_WIPE_ACK`: a set, clear or wipe was accepted on the last edge.

On every edge the next state is picked from the opcode. NONE goes to `ST_IDLE`, SET to `ST_SET_ACK`, CLEAR to `ST_CLR_ACK` and WIPE to `ST_WIPE_ACK`. This does not depend on the current state.

Top module: `bp_slot_bank`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, every slot is empty, `rsp_done` is 0 and `hit` is 0 for any fetch address.
- R2: The opcode encoding is 2'b00 NONE, 2'b01 SET, 2'b10 CLEAR and 2'b11 WIPE. A NONE opcode changes no slot and gives no response.
- R3: A SET writes `{cmd_addr[31:1],1'b1}` into the lowest-indexed slot whose value is zero, and reports that index with both flags at 0.
- R4: A SET whose forced value already sits in a slot changes nothing. It reports that slot's index with both flags at 0, so addresses that differ only in bit 0 count as duplicates.
- R5: A SET into a bank with no free slot writes nothing. It reports `rsp_full`=1, `rsp_miss`=0 and `rsp_slot`=0.
- R6: A CLEAR zeroes the slot holding `{cmd_addr[31:1],1'b1}` and reports its index with both flags at 0.
- R7: A CLEAR that matches no slot changes nothing. It reports `rsp_miss`=1, `rsp_full`=0 and `rsp_slot`=0.
- R8: A WIPE zeroes all slots on one edge and reports `rsp_slot`=0 with both flags at 0.
- R9: `hit` is combinational. It is 1 exactly when `fetch_valid` is 1 and `fetch_addr[31:1]` equals bits [31:1] of some non-zero slot.
- R10: `rsp_done` is 1 for exactly the one cycle after each edge on which the opcode was not NONE. The other response outputs are meaningful only while `rsp_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command opcode (R2 encoding) |
| cmd_addr | input | 32 | Breakpoint address for SET and CLEAR |
| fetch_valid | input | 1 | The fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address to compare |
| hit | output | 1 | Fetch address matches an occupied slot |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_slot | output | 3 | Slot index affected by the command |
| rsp_miss | output | 1 | CLEAR found no matching slot |
| rsp_full | output | 1 | SET found no free slot |

## Verification
The bank is filled in order with distinct addresses to show that allocation takes the lowest free index. An address is then re-set with its low bit flipped, which separates duplicate detection from a plain compare. Further stimulus clears a middle slot and sets again to show that a hole is reused, sets into a full bank, clears an address that is absent, and issues idle opcodes, so that each of the four response shapes is shown apart from the others. A long random run then mixes all opcodes over a small address pool, with fetches on every cycle. This drives the bank through repeated collisions, refills and wipes. A behavioural slot array checks both `hit` and the response on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_SET   = 2'b01,
        OP_CLEAR = 2'b10,
        OP_WIPE  = 2'b11
    } bp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SET_ACK,
        ST_CLR_ACK,
        ST_WIPE_ACK
    } bp_state_e;
endpackage

// File: rtl/bp_slot_regs.sv
module bp_slot_regs #(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [ADDR_W-1:0]            wr_data,
    input  logic                         wipe,
    output logic [SLOTS-1:0][ADDR_W-1:0] slots
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || wipe) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/bp_search.sv
module bp_search #(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0][ADDR_W-1:0] slots,
    input  logic [ADDR_W-1:0]            key,
    output logic                         match_any,
    output logic [IDX_W-1:0]             match_idx,
    output logic                         free_any,
    output logic [IDX_W-1:0]             free_idx
);
    logic [SLOTS-1:0] eq_vec;
    logic [SLOTS-1:0] free_vec;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign eq_vec[g]   = (slots[g] == key);
        assign free_vec[g] = (slots[g] == '0);
    end

    // lowest index wins: scan from the top down so the last write is the lowest
    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (eq_vec[i])   match_idx = IDX_W'(i);
            if (free_vec[i]) free_idx  = IDX_W'(i);
        end
    end

    assign match_any = |eq_vec;
    assign free_any  = |free_vec;
endmodule

// File: rtl/bp_hit.sv
module bp_hit #(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32
) (
    input  logic [SLOTS-1:0][ADDR_W-1:0] slots,
    input  logic                         fetch_valid,
    input  logic [ADDR_W-1:0]            fetch_addr,
    output logic                         hit
);
    logic [SLOTS-1:0] slot_hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign slot_hit[g] = slots[g][0] &&
                             (slots[g][ADDR_W-1:1] == fetch_addr[ADDR_W-1:1]);
    end

    assign hit = fetch_valid && (|slot_hit);
endmodule

// File: rtl/bp_slot_bank.sv
module bp_slot_bank
    import bp_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              hit,
    output logic              rsp_done,
    output logic [IDX_W-1:0]  rsp_slot,
    output logic              rsp_miss,
    output logic              rsp_full
);
    bp_op_e    op;
    bp_state_e state_q, state_d;

    logic [SLOTS-1:0][ADDR_W-1:0] slots;
    logic [ADDR_W-1:0]            key;
    logic                         match_any, free_any;
    logic [IDX_W-1:0]             match_idx, free_idx;

    logic                         wr_en, wipe;
    logic [IDX_W-1:0]             wr_idx;
    logic [ADDR_W-1:0]            wr_data;

    logic [IDX_W-1:0]             slot_d, slot_q;
    logic                         miss_d, miss_q, full_d, full_q;

    assign op  = bp_op_e'(cmd_op);
    assign key = {cmd_addr[ADDR_W-1:1], 1'b1};

    bp_slot_regs #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .wipe   (wipe),
        .slots  (slots)
    );

    bp_search #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_search (
        .slots    (slots),
        .key      (key),
        .match_any(match_any),
        .match_idx(match_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    bp_hit #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_hit (
        .slots      (slots),
        .fetch_valid(fetch_valid),
        .fetch_addr (fetch_addr),
        .hit        (hit)
    );

    // next state and command decode
    always_comb begin
        state_d = ST_IDLE;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = '0;
        wipe    = 1'b0;
        slot_d  = '0;
        miss_d  = 1'b0;
        full_d  = 1'b0;
        unique case (op)
            OP_NONE: begin
                state_d = ST_IDLE;
            end
            OP_SET: begin
                state_d = ST_SET_ACK;
                if (match_any) begin
                    slot_d = match_idx;
                end else if (free_any) begin
                    wr_en   = 1'b1;
                    wr_idx  = free_idx;
                    wr_data = key;
                    slot_d  = free_idx;
                end else begin
                    full_d = 1'b1;
                end
            end
            OP_CLEAR: begin
                state_d = ST_CLR_ACK;
                if (match_any) begin
                    wr_en  = 1'b1;
                    wr_idx = match_idx;
                    slot_d = match_idx;
                end else begin
                    miss_d = 1'b1;
                end
            end
            OP_WIPE: begin
                state_d = ST_WIPE_ACK;
                wipe    = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            miss_q  <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            miss_q  <= miss_d;
            full_q  <= full_d;
        end
    end

    // outputs
    always_comb begin
        rsp_done = 1'b0;
        rsp_slot = '0;
        rsp_miss = 1'b0;
        rsp_full = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SET_ACK: begin
                rsp_done = 1'b1;
                rsp_slot = slot_q;
                rsp_full = full_q;
            end
            ST_CLR_ACK: begin
                rsp_done = 1'b1;
                rsp_slot = slot_q;
                rsp_miss = miss_q;
            end
            ST_WIPE_ACK: begin
                rsp_done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bp_slot_bank_chk.sv
module bp_slot_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_op,
    input logic       fetch_valid,
    input logic       hit,
    input logic       rsp_done,
    input logic       rsp_miss,
    input logic       rsp_full
);
    // R10: a command is answered on the next cycle
    a_r10_done_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 2'b00) |=> rsp_done);

    // R2: an idle opcode gives no response
    a_r2_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b00) |=> !rsp_done);

    // R9: no hit without a valid fetch
    a_r9_hit_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !hit);

    // R5: the full flag only answers a SET
    a_r5_full_only_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b01) or 1'b1 |=> (rsp_full |-> $past(cmd_op) == 2'b01));

    // R7: the miss flag only answers a CLEAR
    a_r7_miss_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> ($past(cmd_op) == 2'b10));

    // R8: after a wipe no slot can be hit
    a_r8_wipe_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b11) |=> !hit);

    // R10: flags never both set
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_miss && rsp_full));
endmodule

bind bp_slot_bank bp_slot_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_op     (cmd_op),
    .fetch_valid(fetch_valid),
    .hit        (hit),
    .rsp_done   (rsp_done),
    .rsp_miss   (rsp_miss),
    .rsp_full   (rsp_full)
);

// File: tb/sim_bp_slot_bank.sv
module sim_bp_slot_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_addr = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        hit, rsp_done, rsp_miss, rsp_full;
    logic [2:0]  rsp_slot;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] model [N];
    logic        e_done, e_miss, e_full;
    int          e_slot;

    bp_slot_bank u0 (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .hit(hit),
        .rsp_done(rsp_done), .rsp_slot(rsp_slot), .rsp_miss(rsp_miss),
        .rsp_full(rsp_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_hit(logic fv, logic [31:0] fa);
        for (int i = 0; i < N; i++)
            if (fv && model[i] != 0 && model[i][31:1] == fa[31:1]) return 1'b1;
        return 1'b0;
    endfunction

    // apply one command and fetch, checking hit now and the response a cycle later
    task automatic step(logic [1:0] op, logic [31:0] a, logic fv, logic [31:0] fa, string req);
        logic [31:0] k;
        int found;
        cmd_op = op; cmd_addr = a; fetch_valid = fv; fetch_addr = fa;
        #1;
        check("R9", {31'd0, hit}, {31'd0, model_hit(fv, fa)}, "hit");
        k = {a[31:1], 1'b1};
        found = -1;
        e_done = (op != 2'b00); e_miss = 0; e_full = 0; e_slot = 0;
        for (int i = N - 1; i >= 0; i--) if (model[i] == k) found = i;
        if (op == 2'b01) begin
            if (found >= 0) e_slot = found;
            else begin
                int fr = -1;
                for (int i = N - 1; i >= 0; i--) if (model[i] == 0) fr = i;
                if (fr >= 0) begin model[fr] = k; e_slot = fr; end
                else e_full = 1;
            end
        end else if (op == 2'b10) begin
            if (found >= 0) begin model[found] = 0; e_slot = found; end
            else e_miss = 1;
        end else if (op == 2'b11) begin
            for (int i = 0; i < N; i++) model[i] = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check("R10", {31'd0, rsp_done}, {31'd0, e_done}, {req, " done"});
        if (e_done) begin
            check(req, {29'd0, rsp_slot}, e_slot, "slot");
            check(req, {31'd0, rsp_miss}, {31'd0, e_miss}, "miss");
            check(req, {31'd0, rsp_full}, {31'd0, e_full}, "full");
        end
        cmd_op = 2'b00;
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        fetch_valid = 1; fetch_addr = 32'h1;
        #1;
        check("R1", {31'd0, hit}, 32'd0, "hit in reset");
        check("R1", {31'd0, rsp_done}, 32'd0, "done in reset");
        @(negedge clk);
        rst_n = 1;
        step(2'b00, 32'h0, 1, 32'h0, "R1");

        // R3 fill in order
        for (int i = 0; i < N; i++)
            step(2'b01, 32'h1000 + i * 16, 1, 32'h1000 + i * 16, "R3");
        // R4 duplicate with flipped low bit
        step(2'b01, 32'h1021, 1, 32'h1020, "R4");
        // R5 full bank
        step(2'b01, 32'h9000, 1, 32'h9000, "R5");
        // R6 clear middle slot, then R3 reuse of the hole
        step(2'b10, 32'h1030, 1, 32'h1031, "R6");
        step(2'b00, 32'h0, 1, 32'h1030, "R2");
        step(2'b01, 32'h9001, 1, 32'h9000, "R3");
        // R7 clear absent
        step(2'b10, 32'h7770, 1, 32'h7770, "R7");
        // R9 fetch not valid
        step(2'b00, 32'h0, 0, 32'h1000, "R9");
        // R8 wipe
        step(2'b11, 32'h0, 1, 32'h1000, "R8");
        step(2'b00, 32'h0, 1, 32'h1000, "R8");
        step(2'b01, 32'h0, 1, 32'h0, "R3");

        // random mix over a small pool
        for (int n = 0; n < 2000; n++) begin
            logic [1:0] op;
            int r;
            r = $urandom_range(0, 99);
            op = (r < 45) ? 2'b01 : (r < 80) ? 2'b10 : (r < 97) ? 2'b00 : 2'b11;
            step(op, 32'h400 + ($urandom_range(0, 11) * 2) + $urandom_range(0, 1),
                 1'($urandom_range(0, 1)), 32'h400 + $urandom_range(0, 25),
                 op == 2'b01 ? "R3" : op == 2'b10 ? "R6" : op == 2'b11 ? "R8" : "R2");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule